// File: doc/BRIEF.md
# Row Line Sequencer for a Directly Addressed Image Sensor

This block produces the row-level control strobes of a CMOS image sensor whose rows are picked by loading an address over a shared 10-bit bus. A frame scheduler hands it one row slot at a time. Each slot carries the row to read, the row to reset for the rolling shutter, and an optional request for the output-amplifier calibration pulse. All of its timing comes from the system clock through parameters given in clock cycles.

In each slot the block first latches the read row onto the bus with an active-low load strobe and waits for the row to settle. It then runs a double-sampling sequence on that row: the signal sample strobe, a reset pulse on the same row, a settling gap, and the reset-level sample strobe. After that it raises a row-ready flag for the column controller. It then latches the reset row and pulses reset on it. Only after this does it hand the address bus to the column controller, which holds it until it acknowledges the row.

The calibration pulse is issued at most once per frame. A frame-sync input re-arms it, and it is also armed out of reset. On the pins the bus puts the most significant address bit on bit 0, so every address the block drives goes out bit-reversed.

Top module: `lseq_ctrl`

## Requirements
- R1: While reset is asserted and right after it: `y_load_n_o` is high; `sample_sig_o`, `sample_rst_o`, `row_rst_o` and `cal_o` are low; `busy_o`, `row_ready_o` and `col_gnt_o` are low; `y_addr_o` is zero.
- R2: Suppose `start_i` is sampled high while the block is idle. After T_SETUP cycles of address setup, `y_load_n_o` is low for T_LOAD cycles. During the setup and the load, `y_addr_o` carries the read row bit-reversed: pin bit k equals address bit ADDR_W-1-k.
- R3: `sample_sig_o` rises T_SETTLE cycles after `y_load_n_o` returns high for the read row, and stays high for T_SR cycles.
- R4: `row_rst_o` is high for T_RST cycles starting in the cycle in which `sample_sig_o` falls. T_RGAP cycles after `row_rst_o` falls, `sample_rst_o` is high for T_SR cycles.
- R5: The read row stays on `y_addr_o` from the first setup cycle until the last cycle of `sample_rst_o`, including the cycle after the load strobe rises.
- R6: `row_ready_o` rises in the cycle after `sample_rst_o` falls. It stays high until `col_ack_i` is sampled high while it is set, and falls in the next cycle.
- R7: After `sample_rst_o` the reset row is driven bit-reversed on `y_addr_o`. The sequence is T_SETUP setup cycles, T_LOAD cycles with `y_load_n_o` low, T_RPRE cycles of wait, T_RST cycles with `row_rst_o` high, and then T_HOLD cycles of address hold.
- R8: If calibration was granted for the slot, `cal_o` rises T_CAL_DLY cycles after `sample_sig_o` rises and stays high for T_CAL cycles. Otherwise `cal_o` stays low.
- R9: Calibration is granted only if it is armed when the slot is accepted with `cal_req_i` high. Granting it disarms it. Reset and a `frame_sync_i` pulse arm it. A request made while disarmed leaves `cal_o` low.
- R10: `col_gnt_o` equals `col_req_i` whenever the block is idle or waiting for the acknowledge, and is low otherwise. While granted, `y_addr_o` carries `col_addr_i` bit-reversed.
- R11: `busy_o` is high from the cycle after a start is accepted until the slot ends. A slot ends after the hold of R7, or after the acknowledge if that comes later. `start_i` has no effect while `busy_o` is high.
- R12: No two of `sample_sig_o`, `sample_rst_o` and `row_rst_o` are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a row slot (accepted when idle) |
| read_row_i | input | ADDR_W | Row to double-sample |
| reset_row_i | input | ADDR_W | Row to reset for the rolling shutter |
| cal_req_i | input | 1 | Request calibration pulse in this slot |
| frame_sync_i | input | 1 | Re-arms the calibration pulse |
| col_req_i | input | 1 | Column controller asks for the address bus |
| col_addr_i | input | ADDR_W | Column address from the column controller |
| col_ack_i | input | 1 | Column controller has finished the row |
| y_addr_o | output | ADDR_W | Sensor address bus, bit-reversed |
| y_load_n_o | output | 1 | Row address load strobe, active low |
| sample_sig_o | output | 1 | Column amplifier signal-sample strobe |
| sample_rst_o | output | 1 | Column amplifier reset-level sample strobe |
| row_rst_o | output | 1 | Row reset strobe |
| cal_o | output | 1 | Output amplifier calibration strobe |
| busy_o | output | 1 | A row slot is in progress |
| row_ready_o | output | 1 | Column readout of the row may begin |
| col_gnt_o | output | 1 | Address bus granted to the column controller |

## Verification
Some properties are checked on every cycle: the address stays stable across the load strobe, the three row strobes never overlap, reset follows the signal sample directly, row-ready rises only after the reset-level sample, calibration rises inside the signal sample, and the bus is never granted while a load or reset is in flight. The exact cycle counts of every phase, the bit-reversed address values, the once-per-frame gating of calibration, and the ignoring of starts while busy are shown only by the bench scenarios. The bench compares its own timeline model against every output on every clock. Its scenarios include an early acknowledge during the reset-row phase, a late acknowledge, a start held high across slots, and column bus requests both inside and outside the allowed window.

// File: rtl/lseq_pkg.sv
package lseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_SU,
      ST_RD_LD,
      ST_RD_SETTLE,
      ST_SIG,
      ST_RST,
      ST_GAP,
      ST_RLVL,
      ST_RS_SU,
      ST_RS_LD,
      ST_RS_PRE,
      ST_RS_RST,
      ST_RS_POST,
      ST_WAIT
   } lseq_state_e;

   typedef enum logic [1:0] {
      OWN_NONE,
      OWN_READ,
      OWN_RESET,
      OWN_COL
   } lseq_owner_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lseq_timer.sv
module lseq_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1) begin : g_bad_width
      $error("lseq_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lseq_addr_bus.sv
module lseq_addr_bus
   import lseq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 10,
   parameter bit          PIN_MSB_FIRST = 1'b1
) (
   input  lseq_owner_e       owner_i,
   input  logic [ADDR_W-1:0] read_row_i,
   input  logic [ADDR_W-1:0] reset_row_i,
   input  logic [ADDR_W-1:0] col_addr_i,
   output logic [ADDR_W-1:0] pins_o
);

   logic [ADDR_W-1:0] logical;

   if (ADDR_W < 1) begin : g_bad_width
      $error("lseq_addr_bus: ADDR_W must be at least 1");
   end

   always_comb begin
      unique case (owner_i)
         OWN_READ:  logical = read_row_i;
         OWN_RESET: logical = reset_row_i;
         OWN_COL:   logical = col_addr_i;
         default:   logical = '0;
      endcase
   end

   if (PIN_MSB_FIRST) begin : g_reversed
      for (genvar k = 0; k < ADDR_W; k++) begin : g_bit
         assign pins_o[k] = logical[ADDR_W-1-k];
      end
   end else begin : g_straight
      assign pins_o = logical;
   end

endmodule

// File: rtl/lseq_cal_pulse.sv
module lseq_cal_pulse #(
   parameter int unsigned DLY = 10,
   parameter int unsigned WID = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic frame_sync_i,
   input  logic accept_i,
   input  logic cal_req_i,
   input  logic sig_i,
   output logic cal_o
);

   localparam int unsigned CW = $clog2((DLY > WID ? DLY : WID) + 1);

   typedef enum logic [1:0] {CP_OFF, CP_DLY, CP_HI} cal_phase_e;

   cal_phase_e    phase_q;
   logic [CW-1:0] cnt_q;
   logic          armed_q;
   logic          pending_q;
   logic          sig_q;
   logic          sig_rise;

   if (DLY < 2) begin : g_bad_dly
      $error("lseq_cal_pulse: DLY must be at least 2");
   end
   if (WID < 1) begin : g_bad_wid
      $error("lseq_cal_pulse: WID must be at least 1");
   end

   assign sig_rise = sig_i && !sig_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q   <= 1'b1;
         pending_q <= 1'b0;
         sig_q     <= 1'b0;
      end else begin
         sig_q <= sig_i;
         if (frame_sync_i) begin
            armed_q <= 1'b1;
         end else if (accept_i && cal_req_i && armed_q) begin
            armed_q <= 1'b0;
         end
         if (accept_i) begin
            pending_q <= cal_req_i && armed_q;
         end else if (sig_rise) begin
            pending_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= CP_OFF;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            CP_OFF: begin
               if (sig_rise && pending_q) begin
                  phase_q <= CP_DLY;
                  cnt_q   <= CW'(DLY - 2);
               end
            end
            CP_DLY: begin
               if (cnt_q == '0) begin
                  phase_q <= CP_HI;
                  cnt_q   <= CW'(WID - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            CP_HI: begin
               if (cnt_q == '0) begin
                  phase_q <= CP_OFF;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: phase_q <= CP_OFF;
         endcase
      end
   end

   assign cal_o = (phase_q == CP_HI);

   // R9
   cal_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sig_rise && !pending_q) |=> !cal_o)
      else $error("calibration started without a grant");

endmodule

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
   import lseq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 10,
   parameter bit          PIN_MSB_FIRST = 1'b1,
   parameter int unsigned T_SETUP       = 2,
   parameter int unsigned T_LOAD        = 3,
   parameter int unsigned T_SETTLE      = 360,
   parameter int unsigned T_SR          = 40,
   parameter int unsigned T_RST         = 20,
   parameter int unsigned T_RGAP        = 160,
   parameter int unsigned T_RPRE        = 10,
   parameter int unsigned T_HOLD        = 2,
   parameter int unsigned T_CAL_DLY     = 10,
   parameter int unsigned T_CAL         = 100
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] read_row_i,
   input  logic [ADDR_W-1:0] reset_row_i,
   input  logic              cal_req_i,
   input  logic              frame_sync_i,
   input  logic              col_req_i,
   input  logic [ADDR_W-1:0] col_addr_i,
   input  logic              col_ack_i,
   output logic [ADDR_W-1:0] y_addr_o,
   output logic              y_load_n_o,
   output logic              sample_sig_o,
   output logic              sample_rst_o,
   output logic              row_rst_o,
   output logic              cal_o,
   output logic              busy_o,
   output logic              row_ready_o,
   output logic              col_gnt_o
);

   localparam int unsigned T_MAX = max_u(max_u(max_u(T_SETUP, T_LOAD), max_u(T_SETTLE, T_SR)),
                                         max_u(max_u(T_RST, T_RGAP), max_u(T_RPRE, T_HOLD)));
   localparam int unsigned CNT_W = $clog2(T_MAX + 1);
   localparam int unsigned CAL_SPAN = T_CAL_DLY + T_CAL;
   localparam int unsigned ROW_SPAN = 2 * T_SR + T_RST + T_RGAP;

   // elaboration-time parameter checks
   if (ADDR_W < 1) begin : g_bad_addr
      $error("lseq_ctrl: ADDR_W must be at least 1");
   end
   if (T_SETUP < 1 || T_LOAD < 1 || T_SETTLE < 1 || T_SR < 1) begin : g_bad_read_t
      $error("lseq_ctrl: read-phase durations must be at least 1 cycle");
   end
   if (T_RST < 1 || T_RGAP < 1 || T_RPRE < 1 || T_HOLD < 1) begin : g_bad_reset_t
      $error("lseq_ctrl: reset-phase durations must be at least 1 cycle");
   end
   if (T_CAL_DLY >= T_SR) begin : g_bad_cal_dly
      $error("lseq_ctrl: calibration must rise while the signal sample is high");
   end
   if (CAL_SPAN > ROW_SPAN) begin : g_bad_cal_span
      $error("lseq_ctrl: calibration pulse must end before the reset-level sample ends");
   end

   lseq_state_e       state_q, state_d;
   lseq_owner_e       owner;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_zero;
   int unsigned       dur_d;
   logic [ADDR_W-1:0] rd_row_q;
   logic [ADDR_W-1:0] rs_row_q;
   logic              ready_q;
   logic              accept;

   assign accept = (state_q == ST_IDLE) && start_i;

   // ---------------- phase sequencing ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (start_i) state_d = ST_RD_SU;
         ST_RD_SU:     if (tmr_zero) state_d = ST_RD_LD;
         ST_RD_LD:     if (tmr_zero) state_d = ST_RD_SETTLE;
         ST_RD_SETTLE: if (tmr_zero) state_d = ST_SIG;
         ST_SIG:       if (tmr_zero) state_d = ST_RST;
         ST_RST:       if (tmr_zero) state_d = ST_GAP;
         ST_GAP:       if (tmr_zero) state_d = ST_RLVL;
         ST_RLVL:      if (tmr_zero) state_d = ST_RS_SU;
         ST_RS_SU:     if (tmr_zero) state_d = ST_RS_LD;
         ST_RS_LD:     if (tmr_zero) state_d = ST_RS_PRE;
         ST_RS_PRE:    if (tmr_zero) state_d = ST_RS_RST;
         ST_RS_RST:    if (tmr_zero) state_d = ST_RS_POST;
         ST_RS_POST: begin
            if (tmr_zero) state_d = (ready_q && !col_ack_i) ? ST_WAIT : ST_IDLE;
         end
         ST_WAIT:      if (col_ack_i) state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_RD_SU, ST_RS_SU: dur_d = T_SETUP;
         ST_RD_LD, ST_RS_LD: dur_d = T_LOAD;
         ST_RD_SETTLE:       dur_d = T_SETTLE;
         ST_SIG, ST_RLVL:    dur_d = T_SR;
         ST_RST, ST_RS_RST:  dur_d = T_RST;
         ST_GAP:             dur_d = T_RGAP;
         ST_RS_PRE:          dur_d = T_RPRE;
         ST_RS_POST:         dur_d = T_HOLD;
         default:            dur_d = 1;
      endcase
      tmr_load = (state_d != state_q);
      tmr_val  = CNT_W'(dur_d - 1);
   end

   lseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         rd_row_q <= '0;
         rs_row_q <= '0;
         ready_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            rd_row_q <= read_row_i;
            rs_row_q <= reset_row_i;
         end
         if (state_q == ST_RLVL && tmr_zero) begin
            ready_q <= 1'b1;
         end else if (col_ack_i) begin
            ready_q <= 1'b0;
         end
      end
   end

   // ---------------- strobe decode ----------------
   assign y_load_n_o   = !(state_q == ST_RD_LD || state_q == ST_RS_LD);
   assign sample_sig_o = (state_q == ST_SIG);
   assign sample_rst_o = (state_q == ST_RLVL);
   assign row_rst_o    = (state_q == ST_RST) || (state_q == ST_RS_RST);
   assign busy_o       = (state_q != ST_IDLE);
   assign row_ready_o  = ready_q;

   // ---------------- address bus ownership ----------------
   always_comb begin
      unique case (state_q)
         ST_RD_SU, ST_RD_LD, ST_RD_SETTLE, ST_SIG, ST_RST, ST_GAP, ST_RLVL:
            owner = OWN_READ;
         ST_RS_SU, ST_RS_LD, ST_RS_PRE, ST_RS_RST, ST_RS_POST:
            owner = OWN_RESET;
         default:
            owner = col_req_i ? OWN_COL : OWN_NONE;
      endcase
   end

   assign col_gnt_o = (owner == OWN_COL);

   lseq_addr_bus #(.ADDR_W(ADDR_W), .PIN_MSB_FIRST(PIN_MSB_FIRST)) u_bus (
      .owner_i     (owner),
      .read_row_i  (rd_row_q),
      .reset_row_i (rs_row_q),
      .col_addr_i  (col_addr_i),
      .pins_o      (y_addr_o)
   );

   lseq_cal_pulse #(.DLY(T_CAL_DLY), .WID(T_CAL)) u_cal (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .frame_sync_i (frame_sync_i),
      .accept_i     (accept),
      .cal_req_i    (cal_req_i),
      .sig_i        (sample_sig_o),
      .cal_o        (cal_o)
   );

   // ---------------- assertions ----------------
   // R5
   addr_hold_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!y_load_n_o && $past(!y_load_n_o)) |-> $stable(y_addr_o))
      else $error("address moved while load strobe was low");

   // R5
   addr_hold_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(y_load_n_o) |-> $stable(y_addr_o))
      else $error("address moved as load strobe rose");

   // R12
   no_strobe_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({sample_sig_o, sample_rst_o, row_rst_o}) <= 1)
      else $error("row strobes overlap");

   // R4
   reset_follows_sig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sample_sig_o) |-> row_rst_o)
      else $error("row reset did not follow the signal sample");

   // R6
   ready_after_rlvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(row_ready_o) |-> $past(sample_rst_o))
      else $error("row ready rose without a reset-level sample");

   // R8
   cal_inside_sig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cal_o) |-> sample_sig_o)
      else $error("calibration rose outside the signal sample");

   // R10
   grant_quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_gnt_o |-> (y_load_n_o && !row_rst_o))
      else $error("bus granted during a load or reset");

endmodule

// File: tb/lseq_ctrl_bench.sv
`timescale 1ns/1ps
module lseq_ctrl_bench;

   localparam int AW   = 10;
   localparam int SU   = 2;
   localparam int LD   = 3;
   localparam int STL  = 360;
   localparam int SR   = 40;
   localparam int RSTW = 20;
   localparam int GAP  = 160;
   localparam int PRE  = 10;
   localparam int HLD  = 2;
   localparam int CDLY = 10;
   localparam int CWID = 100;
   // phase boundaries, as offsets from the accepting cycle
   localparam int PA = SU;
   localparam int PB = PA + LD;
   localparam int PC = PB + STL;
   localparam int PD = PC + SR;
   localparam int PE = PD + RSTW;
   localparam int PF = PE + GAP;
   localparam int PG = PF + SR;
   localparam int PH = PG + SU;
   localparam int PI = PH + LD;
   localparam int PJ = PI + PRE;
   localparam int PK = PJ + RSTW;
   localparam int PM = PK + HLD;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start, cal_req, frame_sync, col_req, col_ack;
   logic [AW-1:0] read_row, reset_row, col_addr;
   logic [AW-1:0] y_addr;
   logic          y_load_n, s_sig, s_rst, row_rst, cal, busy, ready, gnt;

   always #2.5 clk = ~clk;

   lseq_ctrl u_lseq_ctrl (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .start_i      (start),
      .read_row_i   (read_row),
      .reset_row_i  (reset_row),
      .cal_req_i    (cal_req),
      .frame_sync_i (frame_sync),
      .col_req_i    (col_req),
      .col_addr_i   (col_addr),
      .col_ack_i    (col_ack),
      .y_addr_o     (y_addr),
      .y_load_n_o   (y_load_n),
      .sample_sig_o (s_sig),
      .sample_rst_o (s_rst),
      .row_rst_o    (row_rst),
      .cal_o        (cal),
      .busy_o       (busy),
      .row_ready_o  (ready),
      .col_gnt_o    (gnt)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit running = 0;
   bit finished = 0;

   // reference model state
   int            cyc = 0;
   int            t0 = -100000;
   bit            m_act = 0;
   bit            m_ready = 0;
   bit            m_cal = 0;
   bit            m_armed = 1;
   logic [AW-1:0] m_rd = '0;
   logic [AW-1:0] m_rs = '0;

   function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
      logic [AW-1:0] r;
      for (int k = 0; k < AW; k++) r[k] = v[AW-1-k];
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_ready = 0; m_cal = 0; m_armed = 1; t0 = -100000;
      end else begin
         if (m_ready && col_ack) m_ready = 0;
         if (m_act && (cyc - t0) == PG) m_ready = 1;
         if (!m_act && start) begin
            m_act = 1;
            t0    = cyc;
            m_rd  = read_row;
            m_rs  = reset_row;
            m_cal = cal_req && m_armed;
            if (m_cal) m_armed = 0;
         end
         if (frame_sync) m_armed = 1;
      end
      cyc++;
      if (m_act && (cyc - t0) > PM && !m_ready) m_act = 0;
   end

   always @(negedge clk) begin
      if (running && rst_n) begin
         int p;
         bit e_ld, e_s, e_rs, e_rst, e_cal, own, e_gnt;
         logic [AW-1:0] e_addr;
         p     = cyc - t0;
         e_ld  = !(m_act && ((p > PA && p <= PB) || (p > PH && p <= PI)));
         e_s   = m_act && p > PC && p <= PD;
         e_rst = m_act && ((p > PD && p <= PE) || (p > PJ && p <= PK));
         e_rs  = m_act && p > PF && p <= PG;
         e_cal = m_cal && p > PC + CDLY && p <= PC + CDLY + CWID;
         own   = m_act && p <= PM;
         e_gnt = col_req && !own;
         e_addr = own ? rev(p <= PG ? m_rd : m_rs) : (e_gnt ? rev(col_addr) : '0);
         chk(y_load_n == e_ld, (p > PG) ? "R7" : "R2", "load strobe", 16'(y_load_n), 16'(e_ld));
         chk(s_sig == e_s, "R3", "signal sample", 16'(s_sig), 16'(e_s));
         chk(row_rst == e_rst, (p > PG) ? "R7" : "R4", "row reset", 16'(row_rst), 16'(e_rst));
         chk(s_rst == e_rs, "R4", "reset-level sample", 16'(s_rst), 16'(e_rs));
         chk(y_addr == e_addr, own ? "R5" : "R10", "address bus", 16'(y_addr), 16'(e_addr));
         chk(ready == m_ready, "R6", "row ready", 16'(ready), 16'(m_ready));
         chk(cal == e_cal, "R8/R9", "calibration", 16'(cal), 16'(e_cal));
         chk(gnt == e_gnt, "R10", "bus grant", 16'(gnt), 16'(e_gnt));
         chk(busy == m_act, "R11", "busy", 16'(busy), 16'(m_act));
         chk(32'(s_sig) + 32'(s_rst) + 32'(row_rst) <= 1, "R12", "strobe overlap",
             16'({s_sig, s_rst, row_rst}), 16'(0));
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic launch(input logic [AW-1:0] rd, input logic [AW-1:0] rs, input bit c);
      read_row = rd; reset_row = rs; cal_req = c; start = 1'b1;
      step(1);
      start = 1'b0; cal_req = 1'b0;
   endtask

   task automatic wait_ready();
      while (ready !== 1'b1) step(1);
   endtask

   task automatic wait_idle();
      while (busy !== 1'b0) step(1);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; start = 0; cal_req = 0; frame_sync = 0; col_req = 0; col_ack = 0;
      read_row = '0; reset_row = '0; col_addr = '0;
      step(4);
      // R1: outputs while in reset
      chk(y_load_n === 1'b1 && {s_sig, s_rst, row_rst, cal, busy, ready, gnt} === 7'b0 && y_addr === '0,
          "R1", "reset state", 16'({y_load_n, s_sig, s_rst, row_rst, cal, busy, ready, gnt}), 16'h80);
      rst_n = 1'b1;
      running = 1;
      step(3);

      // slot 1: no calibration, late acknowledge, column asks during reset-row phase
      launch(10'h001, 10'h3FE, 1'b0);
      wait_ready();
      step(5);
      col_req = 1'b1; col_addr = 10'h123;
      step(60);
      col_ack = 1'b1; step(1); col_ack = 1'b0;
      step(4);
      col_req = 1'b0;
      wait_idle();
      step(3);

      // slot 2: calibration armed from reset; start while busy is ignored; early acknowledge
      launch(10'h2AA, 10'h155, 1'b1);
      step(100);
      read_row = 10'h0FF; start = 1'b1; cal_req = 1'b1; step(1); start = 1'b0; cal_req = 1'b0;
      wait_ready();
      step(3);
      col_ack = 1'b1; step(1); col_ack = 1'b0;
      wait_idle();
      step(2);

      // slot 3: calibration requested without a new frame: stays low
      launch(10'h155, 10'h2AA, 1'b1);
      wait_ready();
      col_ack = 1'b1; step(1); col_ack = 1'b0;
      wait_idle();

      // slot 4: frame sync re-arms; column request held through idle and slot
      frame_sync = 1'b1; step(1); frame_sync = 1'b0;
      col_req = 1'b1; col_addr = 10'h0F0;
      step(5);
      launch(10'h3FF, 10'h000, 1'b1);
      wait_ready();
      step(50);
      col_addr = 10'h00F;
      step(2);
      col_ack = 1'b1; step(1); col_ack = 1'b0;
      wait_idle();
      step(4);
      col_req = 1'b0;

      // slots 5 and 6: start and acknowledge held high back to back
      read_row = 10'h200; reset_row = 10'h001; col_ack = 1'b1; start = 1'b1;
      step(1);
      wait_idle();
      read_row = 10'h0AA;
      wait_ready();
      start = 1'b0;
      wait_idle();
      col_ack = 1'b0;
      step(10);
      finish_run();
   end

endmodule